// File: doc/BRIEF.md
# DMA Descriptor Chain Fetcher

This block walks a per-channel linked list of DMA transfer descriptors held in system memory. Every descriptor is 128 bits long. Every channel owns one fixed 16-byte slot in each of two memory regions: a *head region*, which holds the channel's first descriptor, and a *live region*, which holds the channel's current descriptor. When a start request arrives, the block reads the head descriptor as four 32-bit words and copies it into the channel's live slot. It then shows the decoded fields to a transfer engine.

When the engine reports that the descriptor's beats are used up, the block writes a zero remaining count back into the live slot. A non-zero link field sends the block to the next descriptor at that address, which it also copies into the live slot. A zero link ends the chain, and the block raises a one-cycle completion pulse.

The head and live regions may be disjoint or may be the same region. When they are disjoint, the head slot is only ever read, so the same chain can run again without being reprogrammed. Each region needs 16 bytes times (highest channel used + 1). The memory side is a word-wide request port with a ready handshake and one access in flight at a time.

Top module: `dcf_chain_fetcher`

## Requirements
- R1: After reset the block is idle. `start_ready` is 1, and `mem_req`, `dsc_valid` and `chain_done` are 0. A start is accepted in a cycle where `start_valid` and `start_ready` are both 1, and `start_ready` is 0 in the following cycle.
- R2: The first descriptor of channel c is read as four word reads at addresses `desc_base + 16*c + 0, 4, 8, 12`, in that order.
- R3: Each fetched descriptor is written as four words, in ascending order, to `wb_base + 16*c` before `dsc_valid` rises. While it is presented, the live slot holds an exact copy of it.
- R4: The word layout is as follows. Word 0 bits [15:0] are the control field and bits [31:16] are the beat count. Word 1 is the source address, word 2 the destination address and word 3 the next-descriptor address. `dsc_*` presents these values, and they stay stable with `dsc_valid` held until `xfer_done` is sampled high.
- R5: After `xfer_done`, the block performs exactly one extra write, to word 0 of the live slot. Its bits [31:16] are zero and its bits [15:0] equal the control field. A chain of n descriptors therefore makes 5n writes.
- R6: A non-zero next address makes the block read the next descriptor as four words starting at that address.
- R7: A zero next address ends the chain. `chain_done` is high for exactly one cycle, the block returns to idle, and a chain of n descriptors makes exactly 4n reads.
- R8: With disjoint regions, the head slot still holds its original contents after the chain. With a shared region, the slot ends up holding the last descriptor with a zero count.
- R9: While `mem_req` is waiting for `mem_ready`, the address, direction and write data stay stable. No new request is made while a read response is outstanding.
- R10: The channel and both base addresses are sampled only when a start is accepted. Changing those inputs while a chain is running has no effect on any access.
- R11: The live slots of other channels are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Request to run a channel's chain |
| start_ready | output | 1 | Block is idle and can accept a start |
| start_chan | input | CH_W | Channel index for the start |
| desc_base | input | AW | Head region base address (16-byte aligned) |
| wb_base | input | AW | Live region base address (16-byte aligned) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | DW | Read data |
| dsc_valid | output | 1 | Descriptor presented to the engine |
| dsc_ctrl | output | 16 | Control field |
| dsc_count | output | 16 | Beat count |
| dsc_src | output | AW | Source address |
| dsc_dst | output | AW | Destination address |
| dsc_next | output | AW | Next-descriptor address |
| xfer_done | input | 1 | Engine finished the presented descriptor |
| chain_done | output | 1 | One-cycle pulse at the end of the chain |

## Verification
The bench runs chains of one to eight descriptors on the lowest and highest channel, on disjoint and on shared regions. It uses random memory ready and read latency, and it scrambles the start inputs once each start has been accepted. A design that takes the link from the live slot instead of from the fetched word, or that adds the channel offset to a link address, reads the wrong second descriptor, so the presented fields no longer match. A design that copies before the read completes, skips the zero-count write-back or writes it to the head slot either breaks the live-slot copy check or corrupts the head region in the disjoint case. A design that stops one descriptor early or late produces the wrong number of reads and writes, or the wrong number of presented descriptors.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the descriptor chain fetcher.
// Assumes 32-bit memory words and a 128-bit descriptor of four words.
package dcf_pkg;
    localparam int WORDS      = 4;   // words per descriptor
    localparam int WIX_W      = 2;   // word index width
    localparam int SLOT_SHIFT = 4;   // 16-byte slot per channel

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_RWAIT, ST_WR, ST_SHOW, ST_WBACK, ST_DONE
    } state_t;

    typedef enum logic [1:0] {
        SEL_HEAD, SEL_LIVE, SEL_LINK
    } asel_t;
endpackage

// File: rtl/dcf_addr_gen.sv
`timescale 1ns/1ps
// Address generator: forms the byte address of one descriptor word from
// the selected slot base (head slot, live slot or link) and the word index.
// Assumes bases and link addresses are 16-byte aligned.
module dcf_addr_gen
    import dcf_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CH_W = 3
) (
    input  asel_t             asel,
    input  logic [AW-1:0]     head_base,
    input  logic [AW-1:0]     live_base,
    input  logic [CH_W-1:0]   chan,
    input  logic [AW-1:0]     link,
    input  logic [WIX_W-1:0]  widx,
    output logic [AW-1:0]     addr
);
    logic [AW-1:0] slot_off;
    logic [AW-1:0] base;

    // Pick the descriptor base and add the word offset.
    always_comb begin
        slot_off = AW'(chan) << SLOT_SHIFT;
        case (asel)
            SEL_HEAD: base = head_base + slot_off;
            SEL_LIVE: base = live_base + slot_off;
            default:  base = link;
        endcase
        addr = base + (AW'(widx) << 2);
    end
endmodule

// File: rtl/dcf_desc_store.sv
`timescale 1ns/1ps
// Descriptor store: holds the four words of the current descriptor,
// decodes its fields and supplies write data for the live-slot copy,
// with the beat count forced to zero for the final write-back.
module dcf_desc_store
    import dcf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [WIX_W-1:0]  ld_idx,
    input  logic [DW-1:0]     ld_data,
    input  logic [WIX_W-1:0]  rd_idx,
    input  logic              zero_cnt,
    output logic [DW-1:0]     wdata,
    output logic [DW/2-1:0]   f_ctrl,
    output logic [DW/2-1:0]   f_cnt,
    output logic [DW-1:0]     f_src,
    output logic [DW-1:0]     f_dst,
    output logic [DW-1:0]     f_next
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Capture read data into word i when it arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (ld && (ld_idx == WIX_W'(i)))
                words[i] <= ld_data;
        end
    end

    // Decode fields and select the outgoing word.
    always_comb begin
        f_ctrl = words[0][HALF-1:0];
        f_cnt  = words[0][DW-1:HALF];
        f_src  = words[1];
        f_dst  = words[2];
        f_next = words[3];
        wdata  = words[rd_idx];
        if (zero_cnt)
            wdata = {{HALF{1'b0}}, words[0][HALF-1:0]};
    end
endmodule

// File: rtl/dcf_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accepts a start, latches channel and bases, reads four words,
// copies them to the live slot, presents the descriptor, writes back a zero
// count, then follows the link or ends the chain. One memory access in flight.
module dcf_ctrl
    import dcf_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [CH_W-1:0]   start_chan,
    input  logic [AW-1:0]     desc_base,
    input  logic [AW-1:0]     wb_base,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic              xfer_done,
    input  logic [AW-1:0]     next_addr,
    output logic              start_ready,
    output logic              mem_req,
    output logic              mem_we,
    output asel_t             asel,
    output logic [WIX_W-1:0]  widx,
    output logic              ld,
    output logic              zero_cnt,
    output logic              dsc_valid,
    output logic              chain_done,
    output logic [CH_W-1:0]   chan_q,
    output logic [AW-1:0]     hbase_q,
    output logic [AW-1:0]     lbase_q,
    output logic [AW-1:0]     link_q
);
    localparam logic [WIX_W-1:0] LAST = WIX_W'(WORDS - 1);

    state_t state;
    logic   from_link;

    // State, word index and latched start parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            widx      <= '0;
            from_link <= 1'b0;
            chan_q    <= '0;
            hbase_q   <= '0;
            lbase_q   <= '0;
            link_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_valid) begin
                    chan_q    <= start_chan;
                    hbase_q   <= desc_base;
                    lbase_q   <= wb_base;
                    from_link <= 1'b0;
                    widx      <= '0;
                    state     <= ST_RD;
                end
                ST_RD: if (mem_ready) state <= ST_RWAIT;
                ST_RWAIT: if (mem_rvalid) begin
                    if (widx == LAST) begin
                        widx  <= '0;
                        state <= ST_WR;
                    end else begin
                        widx  <= widx + 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_WR: if (mem_ready) begin
                    if (widx == LAST) begin
                        widx  <= '0;
                        state <= ST_SHOW;
                    end else begin
                        widx  <= widx + 1'b1;
                    end
                end
                ST_SHOW: if (xfer_done) state <= ST_WBACK;
                ST_WBACK: if (mem_ready) begin
                    if (next_addr == '0) begin
                        state <= ST_DONE;
                    end else begin
                        link_q    <= next_addr;
                        from_link <= 1'b1;
                        state     <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode state into handshake and datapath controls.
    always_comb begin
        start_ready = (state == ST_IDLE);
        mem_req     = (state == ST_RD) || (state == ST_WR) || (state == ST_WBACK);
        mem_we      = (state == ST_WR) || (state == ST_WBACK);
        asel        = (state == ST_RD) ? (from_link ? SEL_LINK : SEL_HEAD) : SEL_LIVE;
        ld          = (state == ST_RWAIT) && mem_rvalid;
        zero_cnt    = (state == ST_WBACK);
        dsc_valid   = (state == ST_SHOW);
        chain_done  = (state == ST_DONE);
    end

    // R1: an accepted start leaves the idle state on the next cycle.
    p_start_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready) |=> !start_ready);

    // R7: the completion pulse lasts one cycle and is followed by idle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> (!chain_done && start_ready));

    // R9: no request is raised while a read response is outstanding.
    p_no_req_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=> !mem_req);
endmodule

// File: rtl/dcf_chain_fetcher.sv
`timescale 1ns/1ps
// Top: DMA descriptor chain fetcher. Connects the sequencer, the address
// generator and the descriptor store. Assumes 16-byte aligned bases and a
// memory that returns read data at least one cycle after acceptance.
module dcf_chain_fetcher
    import dcf_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [CH_W-1:0]   start_chan,
    input  logic [AW-1:0]     desc_base,
    input  logic [AW-1:0]     wb_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              dsc_valid,
    output logic [15:0]       dsc_ctrl,
    output logic [15:0]       dsc_count,
    output logic [AW-1:0]     dsc_src,
    output logic [AW-1:0]     dsc_dst,
    output logic [AW-1:0]     dsc_next,
    input  logic              xfer_done,
    output logic              chain_done
);
    asel_t             asel;
    logic [WIX_W-1:0]  widx;
    logic              ld;
    logic              zero_cnt;
    logic [CH_W-1:0]   chan_q;
    logic [AW-1:0]     hbase_q;
    logic [AW-1:0]     lbase_q;
    logic [AW-1:0]     link_q;
    logic [DW/2-1:0]   f_ctrl;
    logic [DW/2-1:0]   f_cnt;

    dcf_ctrl #(.AW(AW), .CH_W(CH_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_chan(start_chan),
        .desc_base(desc_base), .wb_base(wb_base),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .xfer_done(xfer_done), .next_addr(dsc_next),
        .start_ready(start_ready), .mem_req(mem_req), .mem_we(mem_we),
        .asel(asel), .widx(widx), .ld(ld), .zero_cnt(zero_cnt),
        .dsc_valid(dsc_valid), .chain_done(chain_done),
        .chan_q(chan_q), .hbase_q(hbase_q), .lbase_q(lbase_q), .link_q(link_q)
    );

    dcf_addr_gen #(.AW(AW), .CH_W(CH_W)) u_addr (
        .asel(asel), .head_base(hbase_q), .live_base(lbase_q),
        .chan(chan_q), .link(link_q), .widx(widx), .addr(mem_addr)
    );

    dcf_desc_store #(.DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld(ld), .ld_idx(widx), .ld_data(mem_rdata),
        .rd_idx(widx), .zero_cnt(zero_cnt), .wdata(mem_wdata),
        .f_ctrl(f_ctrl), .f_cnt(f_cnt),
        .f_src(dsc_src), .f_dst(dsc_dst), .f_next(dsc_next)
    );

    // Map store fields onto the 16-bit engine outputs.
    always_comb begin
        dsc_ctrl  = 16'(f_ctrl);
        dsc_count = 16'(f_cnt);
    end

    // R9: a stalled request keeps its address, direction and data.
    p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R4: the presented descriptor holds steady until the engine finishes.
    p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && !xfer_done) |=> (dsc_valid && $stable(dsc_src)
            && $stable(dsc_dst) && $stable(dsc_next) && $stable(dsc_count)
            && $stable(dsc_ctrl)));

    // R1: nothing is requested or presented while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> (!mem_req && !dsc_valid));
endmodule

// File: tb/dcf_chain_fetcher_tb.sv
`timescale 1ns/1ps
// Bench: random chains over a behavioural memory with random ready and
// read latency, a behavioural transfer engine, and directed corner runs.
module dcf_chain_fetcher_tb;
    localparam int NCH  = 8;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int CH_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            start_valid = 1'b0;
    logic            start_ready;
    logic [CH_W-1:0] start_chan = '0;
    logic [AW-1:0]   desc_base = '0;
    logic [AW-1:0]   wb_base = '0;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_ready = 1'b0;
    logic            mem_rvalid = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;
    logic            dsc_valid;
    logic [15:0]     dsc_ctrl, dsc_count;
    logic [AW-1:0]   dsc_src, dsc_dst, dsc_next;
    logic            xfer_done = 1'b0;
    logic            chain_done;

    dcf_chain_fetcher #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_chan(start_chan), .desc_base(desc_base), .wb_base(wb_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dsc_valid(dsc_valid), .dsc_ctrl(dsc_ctrl), .dsc_count(dsc_count),
        .dsc_src(dsc_src), .dsc_dst(dsc_dst), .dsc_next(dsc_next),
        .xfer_done(xfer_done), .chain_done(chain_done)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Behavioural memory: 4 KB of words, logs of accepted addresses.
    logic [31:0] mem [0:1023];
    logic [31:0] rd_log [0:63];
    logic [31:0] wr_log [0:63];
    int n_rd = 0, n_wr = 0, pend = 0;
    logic [31:0] pdata = '0;

    function automatic int wix(input logic [31:0] a);
        return int'(a[11:2]);
    endfunction

    // Memory model: random ready, read data after 1..3 cycles.
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = pdata;
            end
        end
        mem_ready = ($urandom % 3) != 0;
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                mem[wix(mem_addr)] = mem_wdata;
                if (n_wr < 64) wr_log[n_wr] = mem_addr;
                n_wr++;
            end else begin
                pend  = 1 + int'($urandom % 3);
                pdata = mem[wix(mem_addr)];
                if (n_rd < 64) rd_log[n_rd] = mem_addr;
                n_rd++;
            end
        end
    end

    // Expected chain, filled by the run task.
    logic [31:0] e_w0 [0:7];
    logic [31:0] e_w1 [0:7];
    logic [31:0] e_w2 [0:7];
    logic [31:0] e_w3 [0:7];
    int exp_len = 0;
    int shown = 0;
    int run_ch = 0;
    logic [31:0] run_wb = '0;
    bit seen = 1'b0;
    int wait_cnt = 0;

    // Engine model: checks each presented descriptor and finishes it.
    always @(negedge clk) begin
        xfer_done = 1'b0;
        if (rst_n && dsc_valid) begin
            if (!seen) begin
                int s;
                logic [31:0] lb;
                seen = 1'b1;
                s = (shown < 8) ? shown : 7;
                chk(shown < exp_len, "R7 descriptor beyond chain end", shown, exp_len);
                // R4: fields decoded from the word layout
                chk({dsc_count, dsc_ctrl} == e_w0[s] && dsc_src == e_w1[s]
                    && dsc_dst == e_w2[s] && dsc_next == e_w3[s],
                    "R4 presented fields", {dsc_count, dsc_ctrl}, e_w0[s]);
                // R3: live slot already holds an exact copy (R10: latched bases)
                lb = run_wb + 32'(run_ch * 16);
                chk(mem[wix(lb)] == e_w0[s] && mem[wix(lb)+1] == e_w1[s]
                    && mem[wix(lb)+2] == e_w2[s] && mem[wix(lb)+3] == e_w3[s],
                    "R3 live slot copy", mem[wix(lb)], e_w0[s]);
                wait_cnt = int'($urandom % 4);
            end
            if (wait_cnt == 0) begin
                xfer_done = 1'b1;
                seen = 1'b0;
                shown++;
            end else begin
                wait_cnt--;
            end
        end
    end

    int run_id = 0;

    task automatic run_chain(input int ch, input logic [31:0] db,
                             input logic [31:0] wbb, input int len);
        logic [31:0] node [0:7];
        logic [31:0] hslot, lslot, nslot, nb_before;
        bit done_seen, ok;
        for (int i = 0; i < len; i++)
            node[i] = (i == 0) ? db + 32'(ch * 16)
                               : 32'h800 + 32'((run_id % 8) * 128 + i * 16);
        for (int i = 0; i < len; i++) begin
            e_w0[i] = {16'(1 + ($urandom % 65535)), 16'($urandom)};
            e_w1[i] = $urandom;
            e_w2[i] = $urandom;
            e_w3[i] = (i < len - 1) ? node[i+1] : 32'h0;
            mem[wix(node[i])]   = e_w0[i];
            mem[wix(node[i])+1] = e_w1[i];
            mem[wix(node[i])+2] = e_w2[i];
            mem[wix(node[i])+3] = e_w3[i];
        end
        hslot = db + 32'(ch * 16);
        lslot = wbb + 32'(ch * 16);
        nslot = wbb + 32'(((ch + 1) % NCH) * 16);
        nb_before = mem[wix(nslot)];
        exp_len = len; shown = 0; run_ch = ch; run_wb = wbb;
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        start_valid = 1'b1; start_chan = CH_W'(ch); desc_base = db; wb_base = wbb;
        @(negedge clk);
        start_valid = 1'b0;
        // R10: scramble start inputs while the chain runs
        start_chan = CH_W'($urandom);
        desc_base  = $urandom & 32'hFFFF_FFF0;
        wb_base    = $urandom & 32'hFFFF_FFF0;
        done_seen = 1'b0;
        for (int k = 0; k < 4000 && !done_seen; k++) begin
            @(negedge clk);
            if (chain_done) done_seen = 1'b1;
        end
        chk(done_seen, "R7 chain_done reached", 32'(done_seen), 32'd1);
        @(negedge clk);
        chk(!chain_done && start_ready, "R7 single pulse then idle",
            {30'd0, chain_done, start_ready}, 32'd1);
        chk(shown == len, "R7 descriptors presented", shown, len);
        chk(n_rd == 4 * len, "R7 read count", n_rd, 4 * len);
        chk(n_wr == 5 * len, "R5 write count", n_wr, 5 * len);
        ok = 1'b1;
        for (int k = 0; k < 4; k++)
            if (rd_log[k] != hslot + 32'(4 * k)) ok = 1'b0;
        chk(ok, "R2 head slot read order", rd_log[0], hslot);
        ok = 1'b1;
        for (int k = 0; k < 4; k++)
            if (wr_log[k] != lslot + 32'(4 * k)) ok = 1'b0;
        chk(ok && wr_log[4] == lslot, "R3 live slot write order", wr_log[0], lslot);
        ok = 1'b1;
        for (int i = 1; i < len; i++)
            if (rd_log[4*i] != node[i] || rd_log[4*i+3] != node[i] + 32'd12) ok = 1'b0;
        chk(ok, "R6 link followed", ok, 1);
        chk(mem[wix(lslot)] == {16'h0, e_w0[len-1][15:0]}
            && mem[wix(lslot)+3] == 32'h0,
            "R5 zero count write-back", mem[wix(lslot)], {16'h0, e_w0[len-1][15:0]});
        if (db != wbb)
            chk(mem[wix(hslot)] == e_w0[0] && mem[wix(hslot)+1] == e_w1[0],
                "R8 head slot preserved", mem[wix(hslot)], e_w0[0]);
        else
            chk(mem[wix(hslot)] == {16'h0, e_w0[len-1][15:0]},
                "R8 shared slot holds last", mem[wix(hslot)], {16'h0, e_w0[len-1][15:0]});
        chk(mem[wix(nslot)] == nb_before, "R11 other channel slot", mem[wix(nslot)], nb_before);
        run_id++;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(start_ready && !mem_req && !dsc_valid && !chain_done, "R1 reset state",
            {28'd0, start_ready, mem_req, dsc_valid, chain_done}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready && !mem_req, "R1 idle after reset", {31'd0, start_ready}, 32'd1);
        // Directed corners
        run_chain(0, 32'h000, 32'h400, 1);
        run_chain(NCH - 1, 32'h100, 32'h480, 3);
        run_chain(3, 32'h200, 32'h200, 4);        // shared region
        run_chain(5, 32'h300, 32'h500, 8);
        run_chain(NCH - 1, 32'h080, 32'h080, 1);  // shared, single descriptor
        // Random runs
        for (int r = 0; r < 12; r++) begin
            int ch, len;
            logic [31:0] db, wbb;
            ch  = int'($urandom % NCH);
            len = 1 + int'($urandom % 8);
            db  = 32'(($urandom % 4) * 32'h100);
            wbb = ($urandom % 4 == 0) ? db : 32'h400 + 32'(($urandom % 4) * 32'h80);
            run_chain(ch, db, wbb, len);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule